// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Access Decoder

This block stands between an 8-bit host bus and the register file of a two-channel serial controller. Each host access carries a data/control select and a channel select. A data access goes straight to that channel's transmit or receive buffer. A control access is steered indirectly: each channel holds a three-bit register pointer and a bank flag, both loaded by a write to control register 0. The next control access on that channel goes to the register they name.

The write and read maps differ. Several read addresses are fixed aliases of others. The interrupt vector and the interrupt control byte exist once and are shared by both channels. Writes on one channel's register 15 change how that channel decodes two things: a bit redirects writes aimed at register 7 into a hidden companion register, and another bit turns two low-bank read addresses into byte views of an external frame-status word. After any control access to a register other than 0, the pointer falls back to register 0.

The stored write registers are presented on a flat configuration output for the serial engines. Status bytes, receive data and frame-status words come in as inputs from those engines.

Top module: `sccRegAccess`

## Requirements
- R1: When `dataSel` is 1, a write pulses `txWrStb` for the selected channel and a read returns `rxData` of that channel with a `rxRdStb` pulse. The pointer and bank flag are left untouched.
- R2: A control write while the channel's register number is 0 loads the pointer from `wrData[2:0]`. It sets the bank flag exactly when `wrData[5:3]` equals 3'b001; any other code selects the low bank. The register number is 8 × bank flag + pointer.
- R3: A control write to register number 1–15 other than 8 stores `wrData` in that write register, visible on `cfgRegs[ch][n]` from the next cycle. A control write to number 8 pulses `txWrStb` instead. `cfgRegs` entries 0 and 8 always read 0.
- R4: Control reads of numbers 0 and 4 return `rr0Stat`, numbers 1 and 5 return `rr1Stat`, 2 returns the vector view and 3 the pending view of R9. When frame-status mode is off, numbers 6 and 7 return the vector view and the pending view.
- R5: Control reads in the high bank map as follows. 8 returns `rxData` with a `rxRdStb` pulse. 10 and 14 return `rr10Stat`. 11 and 15 return write register 15. 9 returns 0x00.
- R6: When bit 2 of the channel's write register 15 is set, a read of number 6 returns `fsWord[7:0]`. A read of number 7 returns {`fsWord[18:16]`, `fsWord[12:8]`} and pulses `fsPop` for that channel. Bits 15:13 of the word are ignored.
- R7: When bit 0 of the channel's write register 15 is set, a write to number 7 lands in `wr7Prime[ch]` and write register 7 keeps its value. Otherwise `wr7Prime` is unchanged.
- R8: Write registers 2 and 9 are one copy each. A write through either channel shows on both channels' entries the next cycle.
- R9: The vector view on channel A is the stored vector as written. On channel B it is the vector with bits 3:1 replaced by `vecStat`. The pending view is `ipBits` on channel A and 0x00 on channel B.
- R10: Reads of numbers 12 and 13 return the channel's write registers 12 and 13, the time-constant low and high bytes.
- R11: After a control access of either direction to a number other than 0, that channel's pointer and bank flag return to 0. The other channel's pointer is unaffected.
- R12: After reset, all write registers, `wr7Prime`, the pointers and the bank flags are 0. `rdData` is 0x00 in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| dataSel | input | 1 | 1 = data buffer access, 0 = control access |
| chanB | input | 1 | 0 = channel A, 1 = channel B |
| wrData | input | 8 | Write data |
| rxData | input | 2×8 | Receive buffer byte per channel |
| rr0Stat | input | 2×8 | Status byte for read number 0 per channel |
| rr1Stat | input | 2×8 | Status byte for read number 1 per channel |
| rr10Stat | input | 2×8 | Status byte for read number 10 per channel |
| ipBits | input | 8 | Interrupt-pending bits |
| vecStat | input | 3 | Status code placed in the channel B vector |
| fsWord | input | 2×19 | Head of the frame-status FIFO per channel |
| rdData | output | 8 | Read data, valid in the access cycle |
| txWrStb | output | 2 | Transmit buffer write pulse per channel, data on `wrData` |
| rxRdStb | output | 2 | Receive buffer read pulse per channel |
| fsPop | output | 2 | Frame-status FIFO advance pulse per channel |
| cfgRegs | output | 2×16×8 | Write register contents per channel |
| wr7Prime | output | 2×8 | Hidden companion of write register 7 per channel |

## Verification
A corrupt pointer or bank flag shows up on the very next control access. A read returns the wrong status byte, or a write lands on the wrong `cfgRegs` entry one cycle later. A missed fall-back to register 0 turns the following WR0 write into a stray register write, which is visible at once. A wrong shared copy or a wrong redirect flag shows on `cfgRegs` or `wr7Prime` in the cycle after the write. A wrong frame-status mode changes `rdData` and `fsPop` in the access cycle itself. The reference model is compared against every output on every clock, so each such error is reported within one cycle of reaching the ports.

// File: rtl/sccRegPkg.sv
package sccRegPkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_CH    = 2;
  localparam int NUM_REG   = 16;
  localparam int PTR_W     = 3;
  localparam int IDX_W     = PTR_W + 1;
  localparam int FS_W      = 19;
  localparam int VSTAT_W   = 3;
  localparam logic [2:0] POINT_HI_CODE = 3'b001;
  localparam int PRIME_BIT = 0;
  localparam int FSMODE_BIT = 2;

  typedef enum logic [3:0] {
    SRC_ZERO, SRC_RXBUF, SRC_RR0, SRC_RR1, SRC_VEC, SRC_IP,
    SRC_RR10, SRC_TCLO, SRC_TCHI, SRC_WR15, SRC_FSLO, SRC_FSHI
  } rdSrcE;

  typedef struct packed {
    logic             wrEn;
    logic             chan;
    logic [IDX_W-1:0] wrIdx;
    logic             toPrime;
    rdSrcE            rdSrc;
  } accStrobeT;
endpackage

// File: rtl/sccAccessCtrl.sv
module sccAccessCtrl
  import sccRegPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic                  dataSel,
  input  logic                  chanB,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [NUM_CH-1:0]     primeEn,
  input  logic [NUM_CH-1:0]     fsEn,
  output accStrobeT             strobe,
  output logic [NUM_CH-1:0]     txWrStb,
  output logic [NUM_CH-1:0]     rxRdStb,
  output logic [NUM_CH-1:0]     fsPop
);
  logic [NUM_CH-1:0][PTR_W-1:0] ptr;
  logic [NUM_CH-1:0]            ptHi;
  logic [IDX_W-1:0]             regNum;
  logic                         ctlAcc;
  logic [1:0]                   unusedBits;

  assign unusedBits = wrData[7:6];
  assign regNum = {ptHi[chanB], ptr[chanB]};
  assign ctlAcc = busSel && !dataSel;

  always_comb begin
    strobe         = '0;
    strobe.chan    = chanB;
    strobe.wrIdx   = regNum;
    strobe.rdSrc   = SRC_ZERO;
    txWrStb        = '0;
    rxRdStb        = '0;
    fsPop          = '0;
    if (busSel && dataSel) begin
      if (busWr) txWrStb[chanB] = 1'b1;
      else begin
        rxRdStb[chanB] = 1'b1;
        strobe.rdSrc   = SRC_RXBUF;
      end
    end else if (ctlAcc && busWr) begin
      if (regNum == 4'd8) txWrStb[chanB] = 1'b1;
      else if (regNum != '0) begin
        strobe.wrEn    = 1'b1;
        strobe.toPrime = (regNum == 4'd7) && primeEn[chanB];
      end
    end else if (ctlAcc) begin
      case (regNum)
        4'd0, 4'd4:   strobe.rdSrc = SRC_RR0;
        4'd1, 4'd5:   strobe.rdSrc = SRC_RR1;
        4'd2:         strobe.rdSrc = SRC_VEC;
        4'd3:         strobe.rdSrc = SRC_IP;
        4'd6:         strobe.rdSrc = fsEn[chanB] ? SRC_FSLO : SRC_VEC;
        4'd7: begin
          if (fsEn[chanB]) begin
            strobe.rdSrc  = SRC_FSHI;
            fsPop[chanB]  = 1'b1;
          end else strobe.rdSrc = SRC_IP;
        end
        4'd8: begin
          strobe.rdSrc   = SRC_RXBUF;
          rxRdStb[chanB] = 1'b1;
        end
        4'd10, 4'd14: strobe.rdSrc = SRC_RR10;
        4'd11, 4'd15: strobe.rdSrc = SRC_WR15;
        4'd12:        strobe.rdSrc = SRC_TCLO;
        4'd13:        strobe.rdSrc = SRC_TCHI;
        default:      strobe.rdSrc = SRC_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr  <= '0;
      ptHi <= '0;
    end else if (ctlAcc) begin
      if (regNum == '0) begin
        if (busWr) begin
          ptr[chanB]  <= wrData[PTR_W-1:0];
          ptHi[chanB] <= (wrData[5:3] == POINT_HI_CODE);
        end
      end else begin
        ptr[chanB]  <= '0;
        ptHi[chanB] <= 1'b0;
      end
    end
  end

  // R1: a data access never moves either pointer
  p_data_keeps_ptr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && dataSel) |=> ($stable(ptr) && $stable(ptHi)));

  // R5: at most one buffer side effect per cycle
  p_one_side_effect_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txWrStb, rxRdStb, fsPop}));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ptrChk
    // R11: pointer falls back after a non-zero register access
    p_ptr_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
      (ctlAcc && chanB == 1'(c) && {ptHi[c], ptr[c]} != '0)
      |=> (ptr[c] == '0 && !ptHi[c]));
    // R2: WR0 write loads the pointer bits
    p_wr0_load_r2: assert property (@(posedge clk) disable iff (!rstN)
      (ctlAcc && busWr && chanB == 1'(c) && {ptHi[c], ptr[c]} == '0)
      |=> (ptr[c] == $past(wrData[PTR_W-1:0])));
  end
endmodule

// File: rtl/sccRegDatapath.sv
module sccRegDatapath
  import sccRegPkg::*;
(
  input  logic                                    clk,
  input  logic                                    rstN,
  input  accStrobeT                               strobe,
  input  logic [BYTE_W-1:0]                       wrData,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]           rxData,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]           rr0Stat,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]           rr1Stat,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]           rr10Stat,
  input  logic [BYTE_W-1:0]                       ipBits,
  input  logic [VSTAT_W-1:0]                      vecStat,
  input  logic [NUM_CH-1:0][FS_W-1:0]             fsWord,
  output logic [BYTE_W-1:0]                       rdData,
  output logic [NUM_CH-1:0][NUM_REG-1:0][BYTE_W-1:0] cfgRegs,
  output logic [NUM_CH-1:0][BYTE_W-1:0]           wr7Prime,
  output logic [NUM_CH-1:0]                       primeEn,
  output logic [NUM_CH-1:0]                       fsEn
);
  logic [BYTE_W-1:0] vecReg;
  logic [BYTE_W-1:0] icReg;
  logic              ch;
  logic [NUM_CH-1:0][2:0] unusedFs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg <= '0;
      icReg  <= '0;
    end else if (strobe.wrEn) begin
      if (strobe.wrIdx == 4'd2) vecReg <= wrData;
      if (strobe.wrIdx == 4'd9) icReg  <= wrData;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      if (r == 0 || r == 8) begin : g_none
        assign cfgRegs[c][r] = '0;
      end else if (r == 2) begin : g_vec
        assign cfgRegs[c][r] = vecReg;
      end else if (r == 9) begin : g_ic
        assign cfgRegs[c][r] = icReg;
      end else begin : g_own
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q <= '0;
          else if (strobe.wrEn && strobe.chan == 1'(c) &&
                   strobe.wrIdx == IDX_W'(r) && !strobe.toPrime)
            q <= wrData;
        end
        assign cfgRegs[c][r] = q;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wr7Prime[c] <= '0;
      else if (strobe.wrEn && strobe.toPrime && strobe.chan == 1'(c))
        wr7Prime[c] <= wrData;
    end

    assign primeEn[c]  = cfgRegs[c][15][PRIME_BIT];
    assign fsEn[c]     = cfgRegs[c][15][FSMODE_BIT];
    assign unusedFs[c] = fsWord[c][15:13];

    // R7: redirected write leaves WR7 alone and fills the hidden copy
    p_prime_keeps_wr7_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && strobe.toPrime && strobe.chan == 1'(c))
      |=> ($stable(cfgRegs[c][7]) && wr7Prime[c] == $past(wrData)));
  end

  assign ch = strobe.chan;

  always_comb begin
    case (strobe.rdSrc)
      SRC_RXBUF: rdData = rxData[ch];
      SRC_RR0:   rdData = rr0Stat[ch];
      SRC_RR1:   rdData = rr1Stat[ch];
      SRC_VEC:   rdData = ch ? {vecReg[7:4], vecStat, vecReg[0]} : vecReg;
      SRC_IP:    rdData = ch ? '0 : ipBits;
      SRC_RR10:  rdData = rr10Stat[ch];
      SRC_TCLO:  rdData = cfgRegs[ch][12];
      SRC_TCHI:  rdData = cfgRegs[ch][13];
      SRC_WR15:  rdData = cfgRegs[ch][15];
      SRC_FSLO:  rdData = fsWord[ch][7:0];
      SRC_FSHI:  rdData = {fsWord[ch][18:16], fsWord[ch][12:8]};
      default:   rdData = '0;
    endcase
  end

  // R8: shared copies follow writes from either channel
  p_shared_vec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrIdx == 4'd2)
    |=> (cfgRegs[0][2] == $past(wrData) && cfgRegs[1][2] == $past(wrData)));
  p_shared_ic_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrIdx == 4'd9)
    |=> (cfgRegs[0][9] == $past(wrData) && cfgRegs[1][9] == $past(wrData)));
endmodule

// File: rtl/sccRegAccess.sv
module sccRegAccess
  import sccRegPkg::*;
(
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        busSel,
  input  logic                                        busWr,
  input  logic                                        dataSel,
  input  logic                                        chanB,
  input  logic [BYTE_W-1:0]                           wrData,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]               rxData,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]               rr0Stat,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]               rr1Stat,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]               rr10Stat,
  input  logic [BYTE_W-1:0]                           ipBits,
  input  logic [VSTAT_W-1:0]                          vecStat,
  input  logic [NUM_CH-1:0][FS_W-1:0]                 fsWord,
  output logic [BYTE_W-1:0]                           rdData,
  output logic [NUM_CH-1:0]                           txWrStb,
  output logic [NUM_CH-1:0]                           rxRdStb,
  output logic [NUM_CH-1:0]                           fsPop,
  output logic [NUM_CH-1:0][NUM_REG-1:0][BYTE_W-1:0]  cfgRegs,
  output logic [NUM_CH-1:0][BYTE_W-1:0]               wr7Prime
);
  accStrobeT         strobe;
  logic [NUM_CH-1:0] primeEn;
  logic [NUM_CH-1:0] fsEn;

  sccAccessCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .dataSel (dataSel),
    .chanB   (chanB),
    .wrData  (wrData),
    .primeEn (primeEn),
    .fsEn    (fsEn),
    .strobe  (strobe),
    .txWrStb (txWrStb),
    .rxRdStb (rxRdStb),
    .fsPop   (fsPop)
  );

  sccRegDatapath i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rxData   (rxData),
    .rr0Stat  (rr0Stat),
    .rr1Stat  (rr1Stat),
    .rr10Stat (rr10Stat),
    .ipBits   (ipBits),
    .vecStat  (vecStat),
    .fsWord   (fsWord),
    .rdData   (rdData),
    .cfgRegs  (cfgRegs),
    .wr7Prime (wr7Prime),
    .primeEn  (primeEn),
    .fsEn     (fsEn)
  );
endmodule

// File: tb/test_sccRegAccess.sv
`timescale 1ns/1ps
module test_sccRegAccess;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 0, busWr = 0, dataSel = 0, chanB = 0;
  logic [7:0] wrData = '0;
  logic [1:0][7:0] rxData = '0, rr0Stat = '0, rr1Stat = '0, rr10Stat = '0;
  logic [7:0] ipBits = '0;
  logic [2:0] vecStat = '0;
  logic [1:0][18:0] fsWord = '0;
  logic [7:0] rdData;
  logic [1:0] txWrStb, rxRdStb, fsPop;
  logic [1:0][15:0][7:0] cfgRegs;
  logic [1:0][7:0] wr7Prime;

  int checks = 0, failures = 0;
  bit done = 0;

  int mPtr[2];
  bit mHi[2];
  logic [7:0] mReg[2][16];
  logic [7:0] mVec, mIc;
  logic [7:0] mPrime[2];

  always #5 clk = ~clk;

  sccRegAccess i_sccRegAccess (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .dataSel(dataSel),
    .chanB(chanB), .wrData(wrData), .rxData(rxData), .rr0Stat(rr0Stat),
    .rr1Stat(rr1Stat), .rr10Stat(rr10Stat), .ipBits(ipBits), .vecStat(vecStat),
    .fsWord(fsWord), .rdData(rdData), .txWrStb(txWrStb), .rxRdStb(rxRdStb),
    .fsPop(fsPop), .cfgRegs(cfgRegs), .wr7Prime(wr7Prime));

  task automatic chk(input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mPtr[c] = 0; mHi[c] = 0; mPrime[c] = '0;
      for (int r = 0; r < 16; r++) mReg[c][r] = '0;
    end
    mVec = '0; mIc = '0;
  endtask

  // One bus cycle: drive at negedge, compare before the next posedge, then advance the model.
  task automatic acc(input bit act, input bit dsel, input bit wr, input bit ch,
                     input logic [7:0] d, input string note = "");
    int num;
    bit fsOn, prOn;
    logic [7:0] eRd, vView;
    logic [1:0] eTx, eRx, eFs;
    logic [1:0][15:0][7:0] eCfg;
    logic [1:0][7:0] ePr;
    string tag;
    @(negedge clk);
    busSel = act; dataSel = dsel; busWr = wr; chanB = ch; wrData = d;
    rxData = 16'($urandom); rr0Stat = 16'($urandom); rr1Stat = 16'($urandom);
    rr10Stat = 16'($urandom); ipBits = 8'($urandom); vecStat = 3'($urandom);
    fsWord = 38'({$urandom, $urandom});
    #4;
    num = (mHi[ch] ? 8 : 0) + mPtr[ch];
    fsOn = mReg[ch][15][2];
    prOn = mReg[ch][15][0];
    eRd = '0; eTx = '0; eRx = '0; eFs = '0; tag = "R12";
    vView = ch ? {mVec[7:4], vecStat, mVec[0]} : mVec;
    for (int c = 0; c < 2; c++) begin
      ePr[c] = mPrime[c];
      for (int r = 0; r < 16; r++)
        eCfg[c][r] = (r == 0 || r == 8) ? 8'h00 : (r == 2) ? mVec : (r == 9) ? mIc : mReg[c][r];
    end
    if (act && dsel) begin
      tag = "R1";
      if (wr) eTx[ch] = 1'b1;
      else begin eRd = rxData[ch]; eRx[ch] = 1'b1; end
    end else if (act && wr) begin
      tag = (num == 0) ? "R2" : (num == 8) ? "R3" : (num == 7 && prOn) ? "R7" :
            (num == 2 || num == 9) ? "R8" : "R3";
      if (num == 8) eTx[ch] = 1'b1;
    end else if (act) begin
      case (num)
        0, 4:   begin eRd = rr0Stat[ch]; tag = "R4"; end
        1, 5:   begin eRd = rr1Stat[ch]; tag = "R4"; end
        2:      begin eRd = vView; tag = "R9"; end
        3:      begin eRd = ch ? 8'h00 : ipBits; tag = "R9"; end
        6:      begin eRd = fsOn ? fsWord[ch][7:0] : vView; tag = fsOn ? "R6" : "R4"; end
        7: begin
          if (fsOn) begin eRd = {fsWord[ch][18:16], fsWord[ch][12:8]}; eFs[ch] = 1'b1; tag = "R6"; end
          else begin eRd = ch ? 8'h00 : ipBits; tag = "R4"; end
        end
        8:      begin eRd = rxData[ch]; eRx[ch] = 1'b1; tag = "R5"; end
        9:      begin eRd = 8'h00; tag = "R5"; end
        10, 14: begin eRd = rr10Stat[ch]; tag = "R5"; end
        11, 15: begin eRd = mReg[ch][15]; tag = "R5"; end
        12:     begin eRd = mReg[ch][12]; tag = "R10"; end
        default: begin eRd = mReg[ch][13]; tag = "R10"; end
      endcase
    end
    if (note != "") tag = {tag, "/", note};
    chk(tag, "rdData",   256'(rdData),   256'(eRd));
    chk(tag, "txWrStb",  256'(txWrStb),  256'(eTx));
    chk(tag, "rxRdStb",  256'(rxRdStb),  256'(eRx));
    chk(tag, "fsPop",    256'(fsPop),    256'(eFs));
    chk(tag, "cfgRegs",  256'(cfgRegs),  256'(eCfg));
    chk(tag, "wr7Prime", 256'(wr7Prime), 256'(ePr));
    if (act && !dsel) begin
      if (wr && num != 0 && num != 8) begin
        if (num == 7 && prOn) mPrime[ch] = d;
        else if (num == 2) mVec = d;
        else if (num == 9) mIc = d;
        else mReg[ch][num] = d;
      end
      if (num == 0) begin
        if (wr) begin mPtr[ch] = int'(d[2:0]); mHi[ch] = (d[5:3] == 3'b001); end
      end else begin
        mPtr[ch] = 0; mHi[ch] = 0;
      end
    end
  endtask

  task automatic idle(input string note = ""); acc(0, 0, 0, 0, 8'h00, note); endtask
  task automatic setPtr(input bit ch, input int n);
    acc(1, 0, 1, ch, {2'b00, (n >= 8) ? 3'b001 : 3'b000, 3'(n)}, "R2");
  endtask
  task automatic wrReg(input bit ch, input int n, input logic [7:0] d);
    setPtr(ch, n); acc(1, 0, 1, ch, d);
  endtask
  task automatic rdReg(input bit ch, input int n);
    setPtr(ch, n); acc(1, 0, 0, ch, 8'h00);
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle("reset");                                   // R12 reset state
    idle();
    // R3 fill every write register on both channels
    for (int c = 0; c < 2; c++)
      for (int r = 1; r < 16; r++)
        wrReg(c[0], r, (r == 15) ? 8'hA0 : 8'((c * 16 + r) * 7 + 3));
    // R4 R5 R9 R10 read every pointer value on both channels
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 16; r++) rdReg(c[0], r);
    // R1 data accesses leave the pointer pending
    setPtr(0, 12);
    acc(1, 1, 0, 0, 8'h00, "R1");
    acc(1, 1, 1, 0, 8'h5A, "R1");
    acc(1, 0, 0, 0, 8'h00, "R1");                    // still reads register 12
    // R11 fall-back after non-zero access; next write is WR0
    setPtr(1, 13);
    acc(1, 0, 1, 1, 8'h3C, "R11");
    acc(1, 0, 0, 1, 8'h00, "R11");                   // number 0 again -> RR0
    setPtr(0, 5);
    acc(1, 0, 0, 1, 8'h00, "R11");                   // other channel untouched
    acc(1, 0, 0, 0, 8'h00, "R11");
    // R2 non-matching bank code stays low
    acc(1, 0, 1, 0, 8'b0001_0100, "R2");
    acc(1, 0, 0, 0, 8'h00, "R2");                    // reads number 4 -> RR0
    // R7 redirect on channel A only
    wrReg(0, 15, 8'h01);
    wrReg(0, 7, 8'hE7);
    wrReg(1, 7, 8'h71);
    wrReg(0, 15, 8'h00);
    wrReg(0, 7, 8'h17);
    // R6 frame-status view on channel B
    wrReg(1, 15, 8'h04);
    rdReg(1, 6); rdReg(1, 7); rdReg(0, 6); rdReg(0, 7);
    // R8 shared copies written through channel B, read through both
    wrReg(1, 2, 8'hF3); wrReg(1, 9, 8'h2D);
    rdReg(0, 2); rdReg(1, 2); rdReg(1, 3);
    wrReg(0, 2, 8'h0E); rdReg(1, 6);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      bit ds = ($urandom % 4) == 0;
      bit w  = $urandom % 2;
      bit ch = $urandom % 2;
      logic [7:0] d = 8'($urandom);
      if (($urandom % 2) == 0) d[5:3] = 3'b001;
      if (($urandom % 8) == 0) idle();
      else acc(1, ds, w, ch, d);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule